// File: doc/BRIEF.md
# Eight-bit GPIO Register Block with Change Interrupts

This block sits on a byte-wide register bus and gives software eight general-purpose pins. A writable output register drives the pad outputs. A read-only input register returns the pad levels after a two-flop synchroniser. A change-status register latches a one for any pin whose synchronised level moves in either direction. Software clears a status bit by writing a one to it. A mask register selects which latched changes reach the single active-high interrupt line.

Detection compares each synchronised pin with its value on the previous cycle. A pin level that has been stable since before a clear is therefore never reported again. Once a status bit is set it stays set, and the pin raises nothing further until software clears the bit. A change that arrives in the same cycle as the clear of its bit is kept.

Top module: `gpio_chg_irq`

## Requirements
- R1: After reset, `pin_out` is 0x00, the change-status register reads 0x00, the mask register reads 0xFF and `irq` is low.
- R2: A write to address 0x9A loads the output register, which drives `pin_out` from the next clock edge and reads back at 0x9A. Bit n drives pin n.
- R3: A read at 0x9B returns `pin_in` as it was two rising edges earlier, through a two-flop synchroniser. Writes to 0x9B change no register.
- R4: A rising or falling level change on `pin_in[n]` sets status bit n at 0xC0 on the third rising edge after the change.
- R5: Writing to 0xC0 clears every status bit written with 1 and leaves every bit written with 0 unchanged.
- R6: If a change is detected on pin n in the same cycle as a write-one-to-clear of bit n, the bit stays set.
- R7: While status bit n is set, further changes on pin n have no visible effect. After a clear, a level that was already present is not reported again.
- R8: The mask register at 0xC1 is read/write with 1 meaning masked. `irq` is high exactly when some status bit is 1 and its mask bit is 0.
- R9: `bus_rdata` is 0x00 for reads of any unmapped address and whenever `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| pin_in | input | 8 | Pad input levels, asynchronous |
| pin_out | output | 8 | Pad output data |
| irq | output | 1 | Active-high interrupt request |

## Verification
The bench checks the exact cycle in which a pin change becomes visible: it reads the status register one cycle too early and then on time. A design with one synchroniser stage too few or too many fails one of those two reads. It lines up a clear of a bit with a fresh change on the same pin. A design that lets the clear win drops the event and reads back 0. It clears a bit while the pin sits at a new level. A design that keeps its change reference from the moment of capture, rather than from the previous cycle, reports the old level again. It also writes to the read-only input address and reads unmapped addresses, which catches address decodes that alias.

// File: rtl/gpio_chg_irq.sv
module gpio_chg_irq #(
  parameter int W  = 8,
  parameter int AW = 8,
  parameter logic [AW-1:0] A_OUT  = 'h9A,
  parameter logic [AW-1:0] A_IN   = 'h9B,
  parameter logic [AW-1:0] A_STAT = 'hC0,
  parameter logic [AW-1:0] A_MASK = 'hC1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  input  logic [W-1:0]  pin_in,
  output logic [W-1:0]  pin_out,
  output logic          irq
);

  logic [W-1:0] out_q, mask_q, stat_q;
  logic [W-1:0] sy1_q, sy2_q, ref_q;
  logic [W-1:0] evt, clr, rd_mux;

  wire wr_out  = bus_wr && (bus_addr == A_OUT);
  wire wr_stat = bus_wr && (bus_addr == A_STAT);
  wire wr_mask = bus_wr && (bus_addr == A_MASK);

  assign evt = sy2_q ^ ref_q;
  assign clr = wr_stat ? bus_wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy1_q  <= '0;
      sy2_q  <= '0;
      ref_q  <= '0;
      out_q  <= '0;
      mask_q <= '1;
      stat_q <= '0;
    end else begin
      sy1_q  <= pin_in;
      sy2_q  <= sy1_q;
      ref_q  <= sy2_q;
      stat_q <= (stat_q & ~clr) | evt;
      if (wr_out)  out_q  <= bus_wdata;
      if (wr_mask) mask_q <= bus_wdata;
    end
  end

  always_comb begin
    case (bus_addr)
      A_OUT:   rd_mux = out_q;
      A_IN:    rd_mux = sy2_q;
      A_STAT:  rd_mux = stat_q;
      A_MASK:  rd_mux = mask_q;
      default: rd_mux = '0;
    endcase
  end

  assign bus_rdata = bus_rd ? rd_mux : '0;
  assign pin_out   = out_q;
  assign irq       = |(stat_q & ~mask_q);

  AST_OUT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_out |=> pin_out == $past(bus_wdata)); // R2

  AST_IN_READONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_IN) |=> ($stable(pin_out) && $stable(mask_q))); // R3

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((stat_q & $past(evt)) == $past(evt))); // R6

  AST_CLEAR_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stat |=> ((stat_q & $past(bus_wdata & ~evt)) == '0)); // R5

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_stat && evt == '0) |=> $stable(stat_q)); // R7

  AST_MASK_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mask && bus_wdata == '1) |=> !irq); // R8

  AST_RD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> bus_rdata == '0); // R9

endmodule

// File: tb/gpio_chg_irq_tb_top.sv
module gpio_chg_irq_tb_top;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [7:0] bus_addr = 0;
  logic       bus_wr = 0, bus_rd = 0;
  logic [7:0] bus_wdata = 0;
  logic [7:0] bus_rdata;
  logic [7:0] pin_in = 0;
  logic [7:0] pin_out;
  logic       irq;

  always #10 clk = ~clk;

  gpio_chg_irq dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .irq(irq)
  );

  int    checks = 0, errors = 0;
  bit    finished = 0;
  logic  probe = 0;
  int    q_sel[$];
  int    q_exp[$];
  string q_tag[$];

  // sel: 0 = bus_rdata, 1 = irq, 2 = pin_out
  always @(negedge clk) begin
    #5;
    if (probe && q_sel.size() > 0) begin
      int sel, exp, act;
      string tag;
      sel = q_sel.pop_front();
      exp = q_exp.pop_front();
      tag = q_tag.pop_front();
      act = (sel == 0) ? int'(bus_rdata) : (sel == 1) ? int'(irq) : int'(pin_out);
      checks++;
      if (act != exp) begin
        errors++;
        $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, input int exp, input string tag);
    @(negedge clk);
    bus_rd = 1; bus_addr = a;
    q_sel.push_back(0); q_exp.push_back(exp); q_tag.push_back(tag);
    probe = 1;
    @(negedge clk);
    bus_rd = 0; probe = 0;
  endtask

  task automatic look(input int sel, input int exp, input string tag);
    @(negedge clk);
    q_sel.push_back(sel); q_exp.push_back(exp); q_tag.push_back(tag);
    probe = 1;
    @(negedge clk);
    probe = 0;
  endtask

  task automatic setpin(input logic [7:0] v);
    @(negedge clk);
    pin_in = v;
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual 0x00 expected 0x01");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1;
    rd(8'h9A, 8'h00, "R1 out reset");
    rd(8'hC0, 8'h00, "R1 status reset");
    rd(8'hC1, 8'hFF, "R1 mask reset");
    look(1, 0, "R1 irq reset");
    look(2, 8'h00, "R1 pin_out reset");

    wr(8'h9A, 8'hA5);
    look(2, 8'hA5, "R2 pin_out");
    rd(8'h9A, 8'hA5, "R2 readback");

    wr(8'h9B, 8'hFF);
    rd(8'h9A, 8'hA5, "R3 write to input ignored, out");
    rd(8'hC1, 8'hFF, "R3 write to input ignored, mask");
    setpin(8'h3C);
    rd(8'h9B, 8'h00, "R3 input one edge after change");
    rd(8'h9B, 8'h3C, "R3 input two edges after change");
    rd(8'hC0, 8'h3C, "R4 rising changes latched");

    wr(8'hC0, 8'hFF);
    idle(3);
    rd(8'hC0, 8'h00, "R7 no re-report after clear");

    setpin(8'h38);
    idle(1);
    rd(8'hC0, 8'h00, "R4 not yet set on second edge");
    rd(8'hC0, 8'h04, "R4 falling change latched");

    setpin(8'h39);
    idle(4);
    rd(8'hC0, 8'h05, "R4 second pin latched");
    wr(8'hC0, 8'h01);
    rd(8'hC0, 8'h04, "R5 zero bits kept");

    look(1, 0, "R8 all masked");
    wr(8'hC1, 8'hFB);
    look(1, 1, "R8 unmasked bit raises irq");
    rd(8'hC1, 8'hFB, "R8 mask readback");
    wr(8'hC1, 8'hFF);
    look(1, 0, "R8 remasked");

    setpin(8'h3D);
    idle(1);
    wr(8'hC0, 8'h04);
    rd(8'hC0, 8'h04, "R6 set wins over clear");
    wr(8'hC0, 8'h04);
    idle(3);
    rd(8'hC0, 8'h00, "R7 held level not reported");

    setpin(8'h3F);
    idle(4);
    rd(8'hC0, 8'h02, "R4 pin1 latched");
    setpin(8'h3D);
    idle(4);
    rd(8'hC0, 8'h02, "R7 further change while set");
    look(1, 0, "R7 irq stays masked");
    wr(8'hC0, 8'h02);
    idle(3);
    rd(8'hC0, 8'h00, "R7 cleared stays clear");

    rd(8'h55, 8'h00, "R9 unmapped read");
    rd(8'hC2, 8'h00, "R9 unmapped next to mask");
    @(negedge clk);
    bus_addr = 8'h9A;
    q_sel.push_back(0); q_exp.push_back(0); q_tag.push_back("R9 no read strobe");
    probe = 1;
    @(negedge clk);
    probe = 0;

    idle(2);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule